// File: doc/BRIEF.md
# Charger Status and Interrupt Indicator

This block turns the internal state of a battery charger controller into two host-facing signals. Both are modelled as pull-low enables for open-drain pins: a 1 on an output means the pin is pulled low, and a 0 means it is released to its pull-up. The status line reports the charge state. It is pulled low steadily while charging. It is released when charging is complete or the charger sleeps. It blinks with a 50% duty cycle while charging is suspended by a fault. A two-bit monitor field can silence the status line.

The interrupt line gives a fixed-width low pulse each time the controller raises its one-cycle event strobe. Typical events are the input source being qualified as good, or source type detection finishing. Pulse width and blink half-period are counted in strobes of a microsecond-scale tick input. With default parameters this gives a 256 µs pulse and a 1 Hz blink. A bench can shorten both through the parameters.

Top module: `chg_indicator`

## Requirements
- R1: While reset is asserted, and after release with state code 2'b00 and no event, both outputs are 0 (released).
- R2: With the monitor field not equal to 2'b11 and state code 2'b01 (charging), the status output is 1 in the cycle after those inputs are sampled.
- R3: With the monitor field not equal to 2'b11 and state code 2'b00 (sleep) or 2'b10 (complete), the status output is 0 in the cycle after those inputs are sampled.
- R4: While state code 2'b11 (fault suspend) is held with the monitor enabled, the status output alternates: 1 for BLINK_HALF_TICKS tick strobes, then 0 for BLINK_HALF_TICKS tick strobes, repeating.
- R5: On each entry into the enabled fault-suspend condition, the blink restarts in its pulled-low half with the tick count cleared, so the status output is 1 in the next cycle.
- R6: Monitor field value 2'b11 disables the status output, which is then 0 whatever the state code. Values 2'b00, 2'b01 and 2'b10 enable it.
- R7: An event strobe makes the interrupt output 1 from the next cycle. It stays 1 until PULSE_TICKS tick strobes have been sampled after the event cycle, then returns to 0. A tick in the event cycle is not counted.
- R8: An event arriving while a pulse is active restarts the full PULSE_TICKS width from that event.
- R9: Tick strobes with no event never make the interrupt output 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chg_state_i | input | 2 | Charge state: 00 sleep, 01 charging, 10 complete, 11 fault suspend |
| evt_i | input | 1 | One-cycle strobe for a reportable event |
| mon_mode_i | input | 2 | Monitor field: 11 disables the status output |
| tick_i | input | 1 | One-cycle timebase strobe (nominally 1 µs) |
| stat_pull_o | output | 1 | Status pin pull-low enable |
| irq_pull_o | output | 1 | Interrupt pin pull-low enable |

## Verification
The assertions take evt_i and tick_i to be strobes sampled only at rising edges. They take every input to be a known value from reset release onward, and the parameters to be at least 1. The stimulus drives all inputs on falling edges. Ticks come on every cycle during the directed corner cases and on about half of the cycles during the random phase. State and monitor changes are kept rare there, so that full blink half-periods and full pulses occur between them.

// File: rtl/chg_ind_pkg.sv
package chg_ind_pkg;

    typedef enum logic [1:0] {
        CHG_SLEEP  = 2'b00,
        CHG_ACTIVE = 2'b01,
        CHG_DONE   = 2'b10,
        CHG_FAULT  = 2'b11
    } chg_state_e;

    localparam logic [1:0] MON_OFF = 2'b11;

endpackage

// File: rtl/chg_stat_drv.sv
module chg_stat_drv
    import chg_ind_pkg::*;
#(
    parameter int unsigned HALF_TICKS = 500000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] state_i,
    input  logic [1:0] mon_i,
    input  logic       tick_i,
    output logic       pull_o
);

    localparam int unsigned BCW = $clog2(HALF_TICKS + 1);

    typedef struct packed {
        logic [BCW-1:0] cnt;
        logic           low_half;
        logic           pull;
    } stat_t;

    stat_t stat_d, stat_q;
    logic  enabled;
    logic  in_fault;

    always_comb begin
        stat_d   = stat_q;
        enabled  = (mon_i != MON_OFF);
        in_fault = enabled && (state_i == CHG_FAULT);
        if (!in_fault) begin
            stat_d.cnt      = '0;
            stat_d.low_half = 1'b1;
            stat_d.pull     = enabled && (state_i == CHG_ACTIVE);
        end else begin
            if (tick_i) begin
                if (stat_q.cnt == BCW'(HALF_TICKS - 1)) begin
                    stat_d.cnt      = '0;
                    stat_d.low_half = ~stat_q.low_half;
                end else begin
                    stat_d.cnt = stat_q.cnt + 1'b1;
                end
            end
            stat_d.pull = stat_d.low_half;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stat_q <= '{cnt: '0, low_half: 1'b1, pull: 1'b0};
        end else begin
            stat_q <= stat_d;
        end
    end

    assign pull_o = stat_q.pull;

    // R6
    mon_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mon_i == MON_OFF) |=> !pull_o);

    // R2
    charging_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mon_i != MON_OFF && state_i == CHG_ACTIVE) |=> pull_o);

    // R3
    idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mon_i != MON_OFF && (state_i == CHG_SLEEP || state_i == CHG_DONE)) |=> !pull_o);

    // R5
    fault_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(in_fault) |=> pull_o);

    // R4
    blink_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_q.cnt < BCW'(HALF_TICKS));

    // R4
    blink_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_fault && !tick_i && stat_q.pull) |=> pull_o);

endmodule

// File: rtl/chg_irq_pulse.sv
module chg_irq_pulse #(
    parameter int unsigned PULSE_TICKS = 256
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic evt_i,
    input  logic tick_i,
    output logic pull_o
);

    localparam int unsigned PCW = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic [PCW-1:0] cnt;
        logic           active;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (evt_i) begin
            irq_d.active = 1'b1;
            irq_d.cnt    = '0;
        end else if (irq_q.active && tick_i) begin
            if (irq_q.cnt == PCW'(PULSE_TICKS - 1)) begin
                irq_d.active = 1'b0;
                irq_d.cnt    = '0;
            end else begin
                irq_d.cnt = irq_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign pull_o = irq_q.active;

    // R7
    evt_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i |=> pull_o);

    // R9
    no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pull_o && !evt_i) |=> !pull_o);

    // R7
    hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pull_o && !tick_i) |=> pull_o);

    // R8
    restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pull_o && evt_i) |=> (pull_o && irq_q.cnt == '0));

    // R7
    width_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_q.cnt < PCW'(PULSE_TICKS));

endmodule

// File: rtl/chg_indicator.sv
module chg_indicator #(
    parameter int unsigned PULSE_TICKS      = 256,
    parameter int unsigned BLINK_HALF_TICKS = 500000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] chg_state_i,
    input  logic       evt_i,
    input  logic [1:0] mon_mode_i,
    input  logic       tick_i,
    output logic       stat_pull_o,
    output logic       irq_pull_o
);

    chg_stat_drv #(
        .HALF_TICKS (BLINK_HALF_TICKS)
    ) u_stat (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .state_i (chg_state_i),
        .mon_i   (mon_mode_i),
        .tick_i  (tick_i),
        .pull_o  (stat_pull_o)
    );

    chg_irq_pulse #(
        .PULSE_TICKS (PULSE_TICKS)
    ) u_irq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (evt_i),
        .tick_i (tick_i),
        .pull_o (irq_pull_o)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!stat_pull_o && !irq_pull_o));

endmodule

// File: tb/chg_indicator_bench.sv
module chg_indicator_bench;

    localparam int unsigned PW   = 6;
    localparam int unsigned HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] st = 2'b00;
    logic       ev = 1'b0;
    logic [1:0] mm = 2'b00;
    logic       tk = 1'b0;
    logic       stat_pull;
    logic       irq_pull;

    int checks = 0;
    int errors = 0;

    // expected-value model state
    logic m_irq;
    int   m_irq_ticks;
    logic m_low;
    int   m_blink_ticks;
    logic m_stat;

    always #5 clk = ~clk;

    chg_indicator #(
        .PULSE_TICKS      (PW),
        .BLINK_HALF_TICKS (HALF)
    ) u_chg_indicator (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .chg_state_i (st),
        .evt_i       (ev),
        .mon_mode_i  (mm),
        .tick_i      (tk),
        .stat_pull_o (stat_pull),
        .irq_pull_o  (irq_pull)
    );

    function automatic string stat_tag(input logic [1:0] s, input logic [1:0] m);
        if (m == 2'b11) return "R6";
        case (s)
            2'b01:   return "R2";
            2'b11:   return "R4";
            default: return "R3";
        endcase
    endfunction

    function void model_reset();
        m_irq = 1'b0; m_irq_ticks = 0;
        m_low = 1'b1; m_blink_ticks = 0; m_stat = 1'b0;
    endfunction

    function void model_edge(input logic [1:0] s, input logic e,
                             input logic [1:0] m, input logic t);
        logic fault_on;
        if (e) begin
            m_irq = 1'b1; m_irq_ticks = 0;
        end else if (m_irq && t) begin
            m_irq_ticks++;
            if (m_irq_ticks == PW) begin m_irq = 1'b0; m_irq_ticks = 0; end
        end
        fault_on = (m != 2'b11) && (s == 2'b11);
        if (fault_on) begin
            if (t) begin
                m_blink_ticks++;
                if (m_blink_ticks == HALF) begin m_blink_ticks = 0; m_low = ~m_low; end
            end
            m_stat = m_low;
        end else begin
            m_low = 1'b1; m_blink_ticks = 0;
            m_stat = (m != 2'b11) && (s == 2'b01);
        end
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic [1:0] s, input logic e, input logic [1:0] m, input logic t);
        @(negedge clk);
        st = s; ev = e; mm = m; tk = t;
        @(posedge clk);
        model_edge(s, e, m, t);
        #1;
        check(stat_tag(s, m), "status", stat_pull, m_stat);
        check(e ? "R7" : (m_irq ? "R7" : "R9"), "interrupt", irq_pull, m_irq);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4711);
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1 during reset
        check("R1", "status in reset", stat_pull, 1'b0);
        check("R1", "interrupt in reset", irq_pull, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 after release, idle; R9 ticks alone do nothing
        for (int i = 0; i < 10; i++) step(2'b00, 1'b0, 2'b00, 1'b1);
        check("R1", "status idle after reset", stat_pull, 1'b0);
        check("R9", "interrupt after ticks only", irq_pull, 1'b0);

        // R7 exact width
        step(2'b00, 1'b1, 2'b00, 1'b1);
        check("R7", "pulse starts", irq_pull, 1'b1);
        for (int i = 0; i < PW - 1; i++) step(2'b00, 1'b0, 2'b00, 1'b1);
        check("R7", "pulse before last tick", irq_pull, 1'b1);
        step(2'b00, 1'b0, 2'b00, 1'b1);
        check("R7", "pulse ended", irq_pull, 1'b0);

        // R8 restart
        step(2'b00, 1'b1, 2'b00, 1'b1);
        for (int i = 0; i < 3; i++) step(2'b00, 1'b0, 2'b00, 1'b1);
        step(2'b00, 1'b1, 2'b00, 1'b1);
        for (int i = 0; i < PW - 1; i++) step(2'b00, 1'b0, 2'b00, 1'b1);
        check("R8", "restarted pulse still low", irq_pull, 1'b1);
        step(2'b00, 1'b0, 2'b00, 1'b1);
        check("R8", "restarted pulse ended", irq_pull, 1'b0);

        // R2, R3, R6
        for (int i = 0; i < 3; i++) step(2'b01, 1'b0, 2'b01, 1'b1);
        check("R2", "charging pulls low", stat_pull, 1'b1);
        step(2'b01, 1'b0, 2'b11, 1'b1);
        check("R6", "disabled while charging", stat_pull, 1'b0);
        step(2'b10, 1'b0, 2'b10, 1'b0);
        check("R3", "complete released", stat_pull, 1'b0);

        // R5 and R4 blink
        step(2'b11, 1'b0, 2'b00, 1'b1);
        check("R5", "fault entry low half", stat_pull, 1'b1);
        for (int i = 0; i < HALF - 1; i++) step(2'b11, 1'b0, 2'b00, 1'b1);
        check("R4", "end of low half", stat_pull, 1'b0);
        step(2'b11, 1'b0, 2'b00, 1'b1);
        step(2'b00, 1'b0, 2'b00, 1'b1);
        step(2'b11, 1'b0, 2'b00, 1'b1);
        check("R5", "re-entry restarts low", stat_pull, 1'b1);
        for (int i = 0; i < 4 * HALF; i++) step(2'b11, 1'b0, 2'b00, 1'b1);
        step(2'b11, 1'b0, 2'b11, 1'b1);
        check("R6", "disabled during fault", stat_pull, 1'b0);
        step(2'b11, 1'b0, 2'b10, 1'b0);
        check("R5", "enable during fault restarts low", stat_pull, 1'b1);

        // random phase
        begin
            logic [1:0] rs = 2'b00;
            logic [1:0] rm = 2'b00;
            for (int i = 0; i < 4000; i++) begin
                if (($urandom % 16) == 0) rs = 2'($urandom);
                if (($urandom % 32) == 0) rm = 2'($urandom);
                step(rs, (($urandom % 20) == 0), rm, (($urandom % 2) == 0));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule